// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A first-level read picks one 1 MB slice of the address space. That slice either maps straight to a 1 MB section or points to a second-level table. The second-level table is either coarse (256 entries) or fine (1024 entries), and its descriptor maps a 64 KB, 4 KB or 1 KB page. Each finished walk is checked against the access type of the domain named in the first-level descriptor and against a 2-bit permission field. For large and small pages, that field is chosen per quarter of the page.

A translation request is taken on a valid/ready handshake. Only one walk runs at a time. `req_ready` is high only while the walker is idle. The table base and the domain access word are sampled together with the request. Descriptor reads use a valid/ready request channel with one read outstanding. The response channel carries only a valid, and the walker always accepts it. A request is held unchanged until `mem_req_ready` is seen. The result is offered on a valid/ready response port and is held unchanged until the consumer raises `rsp_ready`.

Fault codes on `rsp_fault`: 0 no fault, 1 first-level translation fault, 2 second-level translation fault, 3 domain fault, 4 permission fault.

Top module: `ptw_walker`

## Requirements
- R1: The first descriptor read goes to address {tbl_base, VA[31:20], 2'b00}. At most one descriptor read is outstanding at any time.
- R2: A first-level descriptor with type bits [1:0]=00 ends the walk with fault code 1 after exactly one read.
- R3: The domain number is first-level bits [8:5]. Its access type is dom_access[2n+1:2n]. Type 00 (no access) and 10 (reserved) give fault code 3, and no second-level read is made. Type 11 (manager) skips the permission check. Type 01 (client) applies it.
- R4: A first-level type 10 (section) gives PA = {desc[31:20], VA[19:0]} with permission field desc[11:10], after exactly one read.
- R5: A first-level type 01 (coarse) makes a second read at {desc[31:10], VA[19:12], 2'b00}.
- R6: A first-level type 11 (fine) makes a second read at {desc[31:12], VA[19:10], 2'b00}.
- R7: A second-level descriptor with type bits [1:0]=00 gives fault code 2.
- R8: Second-level type 01 (large) gives PA = {desc[31:16], VA[15:0]} and uses permission field desc[5+2k:4+2k], where k=VA[15:14]. Type 10 (small) gives PA = {desc[31:12], VA[11:0]} with k=VA[11:10].
- R9: Second-level type 11 (tiny) gives PA = {desc[31:10], VA[9:0]} with permission field desc[5:4].
- R10: Under a client domain, the permission field is checked as follows; a refused access gives fault code 4.
  - 00: allows only a privileged read.
  - 01: allows any privileged access.
  - 10: also allows a user read.
  - 11: allows everything.
- R11: `req_ready` is low from the cycle after a request is accepted until the response has been taken.
- R12: While `rsp_valid` is high and `rsp_ready` is low, `rsp_pa` and `rsp_fault` stay stable. A non-zero fault code comes with `rsp_pa` = 0.
- R13: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | 32 | Virtual address |
| req_priv | input | 1 | 1 = privileged access, 0 = user |
| req_write | input | 1 | 1 = write, 0 = read |
| tbl_base | input | 18 | Bits [31:14] of the first-level table address |
| dom_access | input | 32 | Sixteen 2-bit domain access types; domain n at [2n+1:2n] |
| mem_req_valid | output | 1 | Descriptor read request valid |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Descriptor byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_pa | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 3 | Fault code |

## Verification
A wrong walk state shows up at the memory port within a cycle or two. Examples are a second read where one was due, a read at the wrong table offset, or a read issued while one is still outstanding. Each walk therefore records the count and the addresses of its descriptor reads. A wrongly chosen permission field or domain entry shows up only in `rsp_fault` and `rsp_pa` when the walk ends. So every subpage index, permission code and domain type is driven through user/privileged and read/write combinations whose outcomes differ. Stalls on both handshakes show whether held values drift while waiting.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int ADDR_W     = 32;
  localparam int NUM_DOM    = 16;
  localparam int DOM_IDX_W  = $clog2(NUM_DOM);
  localparam int L1_ALIGN   = 14;
  localparam int BASE_W     = ADDR_W - L1_ALIGN;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_SECT = 3'd1,
    FLT_PAGE = 3'd2,
    FLT_DOM  = 3'd3,
    FLT_PERM = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    L1_FAULT   = 2'b00,
    L1_COARSE  = 2'b01,
    L1_SECTION = 2'b10,
    L1_FINE    = 2'b11
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_FAULT = 2'b00,
    L2_LARGE = 2'b01,
    L2_SMALL = 2'b10,
    L2_TINY  = 2'b11
  } l2_kind_e;

  typedef enum logic [1:0] {
    DOM_NONE   = 2'b00,
    DOM_CLIENT = 2'b01,
    DOM_RSVD   = 2'b10,
    DOM_MGR    = 2'b11
  } dom_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1_REQ,
    ST_L1_WAIT,
    ST_L2_REQ,
    ST_L2_WAIT,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0]    desc,
  input  logic [ADDR_W-1:0]    va,
  output l1_kind_e             kind,
  output logic [DOM_IDX_W-1:0] dom_idx,
  output logic [ADDR_W-1:0]    sect_pa,
  output logic [1:0]           sect_ap,
  output logic [ADDR_W-1:0]    l2_addr
);
  logic unused_l1;
  assign unused_l1 = ^{desc[9], desc[4:2]};

  assign kind    = l1_kind_e'(desc[1:0]);
  assign dom_idx = desc[5 +: DOM_IDX_W];
  assign sect_pa = {desc[31:20], va[19:0]};
  assign sect_ap = desc[11:10];

  // Coarse tables are 1 KB (256 words), fine tables are 4 KB (1024 words).
  always_comb begin
    if (kind == L1_FINE) l2_addr = {desc[31:12], va[19:10], 2'b00};
    else                 l2_addr = {desc[31:10], va[19:12], 2'b00};
  end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [ADDR_W-1:0] va,
  output logic              is_fault,
  output logic [ADDR_W-1:0] pa,
  output logic [1:0]        ap
);
  logic [1:0] sub_sel;
  l2_kind_e   kind;
  logic       unused_l2;

  assign unused_l2 = ^desc[3:2];
  assign kind      = l2_kind_e'(desc[1:0]);

  always_comb begin
    is_fault = 1'b0;
    pa       = '0;
    sub_sel  = 2'd0;
    case (kind)
      L2_LARGE: begin
        pa      = {desc[31:16], va[15:0]};
        sub_sel = va[15:14];
      end
      L2_SMALL: begin
        pa      = {desc[31:12], va[11:0]};
        sub_sel = va[11:10];
      end
      L2_TINY: begin
        pa      = {desc[31:10], va[9:0]};
        sub_sel = 2'd0;
      end
      default: is_fault = 1'b1;
    endcase
    ap = desc[4 + 2*sub_sel +: 2];
  end
endmodule

// File: rtl/ptw_access_chk.sv
module ptw_access_chk
  import ptw_pkg::*;
(
  input  logic [2*NUM_DOM-1:0] dom_word,
  input  logic [DOM_IDX_W-1:0] dom_idx,
  input  logic                 use_live,
  input  dom_e                 dtype_held,
  input  logic [1:0]           ap,
  input  logic                 priv,
  input  logic                 wr,
  output dom_e                 dtype_live,
  output fault_e               flt
);
  logic [1:0] dom_tbl [NUM_DOM];
  dom_e       dtype;
  logic       allowed;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    assign dom_tbl[g] = dom_word[2*g +: 2];
  end

  assign dtype_live = dom_e'(dom_tbl[dom_idx]);
  assign dtype      = use_live ? dtype_live : dtype_held;

  always_comb begin
    case (ap)
      2'b00:   allowed = priv & ~wr;
      2'b01:   allowed = priv;
      2'b10:   allowed = priv | ~wr;
      default: allowed = 1'b1;
    endcase
  end

  always_comb begin
    case (dtype)
      DOM_MGR:    flt = FLT_NONE;
      DOM_CLIENT: flt = allowed ? FLT_NONE : FLT_PERM;
      default:    flt = FLT_DOM;
    endcase
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [ADDR_W-1:0]    req_va,
  input  logic                 req_priv,
  input  logic                 req_write,
  input  logic [BASE_W-1:0]    tbl_base,
  input  logic [2*NUM_DOM-1:0] dom_access,
  output logic                 mem_req_valid,
  input  logic                 mem_req_ready,
  output logic [ADDR_W-1:0]    mem_req_addr,
  input  logic                 mem_rsp_valid,
  input  logic [ADDR_W-1:0]    mem_rsp_data,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [ADDR_W-1:0]    rsp_pa,
  output logic [2:0]           rsp_fault
);
  walk_st_e             st;
  logic [ADDR_W-1:0]    va_q;
  logic                 priv_q;
  logic                 wr_q;
  logic [BASE_W-1:0]    base_q;
  logic [2*NUM_DOM-1:0] dom_q;
  dom_e                 dtype_q;
  logic [ADDR_W-1:0]    l2_addr_q;
  logic [ADDR_W-1:0]    pa_q;
  fault_e               flt_q;

  l1_kind_e             l1_kind;
  logic [DOM_IDX_W-1:0] l1_dom;
  logic [ADDR_W-1:0]    l1_sect_pa;
  logic [1:0]           l1_sect_ap;
  logic [ADDR_W-1:0]    l1_l2_addr;
  logic                 l2_fault;
  logic [ADDR_W-1:0]    l2_pa;
  logic [1:0]           l2_ap;
  logic                 in_l1;
  logic [1:0]           chk_ap;
  dom_e                 dtype_now;
  fault_e               chk_flt;

  ptw_l1_decode u_l1 (
    .desc    (mem_rsp_data),
    .va      (va_q),
    .kind    (l1_kind),
    .dom_idx (l1_dom),
    .sect_pa (l1_sect_pa),
    .sect_ap (l1_sect_ap),
    .l2_addr (l1_l2_addr)
  );

  ptw_l2_decode u_l2 (
    .desc     (mem_rsp_data),
    .va       (va_q),
    .is_fault (l2_fault),
    .pa       (l2_pa),
    .ap       (l2_ap)
  );

  assign in_l1  = (st == ST_L1_WAIT);
  assign chk_ap = in_l1 ? l1_sect_ap : l2_ap;

  ptw_access_chk u_chk (
    .dom_word   (dom_q),
    .dom_idx    (l1_dom),
    .use_live   (in_l1),
    .dtype_held (dtype_q),
    .ap         (chk_ap),
    .priv       (priv_q),
    .wr         (wr_q),
    .dtype_live (dtype_now),
    .flt        (chk_flt)
  );

  assign req_ready     = (st == ST_IDLE);
  assign mem_req_valid = (st == ST_L1_REQ) || (st == ST_L2_REQ);
  assign mem_req_addr  = (st == ST_L2_REQ) ? l2_addr_q
                                           : {base_q, va_q[31:20], 2'b00};
  assign rsp_valid     = (st == ST_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_fault     = flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      va_q      <= '0;
      priv_q    <= 1'b0;
      wr_q      <= 1'b0;
      base_q    <= '0;
      dom_q     <= '0;
      dtype_q   <= DOM_NONE;
      l2_addr_q <= '0;
      pa_q      <= '0;
      flt_q     <= FLT_NONE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            va_q   <= req_va;
            priv_q <= req_priv;
            wr_q   <= req_write;
            base_q <= tbl_base;
            dom_q  <= dom_access;
            st     <= ST_L1_REQ;
          end
        end
        ST_L1_REQ: begin
          if (mem_req_ready) st <= ST_L1_WAIT;
        end
        ST_L1_WAIT: begin
          if (mem_rsp_valid) begin
            if (l1_kind == L1_FAULT) begin
              flt_q <= FLT_SECT;
              pa_q  <= '0;
              st    <= ST_RESP;
            end else if (chk_flt == FLT_DOM) begin
              flt_q <= FLT_DOM;
              pa_q  <= '0;
              st    <= ST_RESP;
            end else if (l1_kind == L1_SECTION) begin
              flt_q <= chk_flt;
              pa_q  <= (chk_flt == FLT_NONE) ? l1_sect_pa : '0;
              st    <= ST_RESP;
            end else begin
              l2_addr_q <= l1_l2_addr;
              dtype_q   <= dtype_now;
              st        <= ST_L2_REQ;
            end
          end
        end
        ST_L2_REQ: begin
          if (mem_req_ready) st <= ST_L2_WAIT;
        end
        ST_L2_WAIT: begin
          if (mem_rsp_valid) begin
            if (l2_fault) begin
              flt_q <= FLT_PAGE;
              pa_q  <= '0;
            end else begin
              flt_q <= chk_flt;
              pa_q  <= (chk_flt == FLT_NONE) ? l2_pa : '0;
            end
            st <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (rsp_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_valid,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_pa,
  input logic [2:0]  rsp_fault
);
  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            pending <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pending <= 1'b1;
    else if (mem_rsp_valid)                pending <= 1'b0;
  end

  assert_single_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !mem_req_valid);

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault)));

  assert_fault_zero_pa_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == 32'd0));

  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid || pending) |-> !req_ready);

  assert_fault_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault <= 3'd4));
endmodule

bind ptw_walker ptw_checker u_ptw_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_pa        (rsp_pa),
  .rsp_fault     (rsp_fault)
);

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;
  localparam int CLK_PERIOD = 10;
  localparam logic [17:0] TBASE = 18'h00010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        req_priv = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] dom_access;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_pa;
  logic [2:0]  rsp_fault;

  logic [31:0] mem_model [logic [31:0]];
  int          checks = 0;
  int          errors = 0;
  bit          stall_en = 1'b0;
  bit          have_pend = 1'b0;
  logic [31:0] pend_addr;
  int          rd_cnt;
  logic [31:0] rd_addr [4];
  logic [31:0] got_pa;
  logic [2:0]  got_flt;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_priv(req_priv), .req_write(req_write),
    .tbl_base(TBASE), .dom_access(dom_access),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_pa(rsp_pa), .rsp_fault(rsp_fault)
  );

  // domain 0 client, 1 manager, 2 no access, 3 reserved, rest client
  initial begin
    dom_access = '0;
    for (int i = 0; i < 16; i++) dom_access[2*i +: 2] = 2'b01;
    dom_access[3:2] = 2'b11;
    dom_access[5:4] = 2'b00;
    dom_access[7:6] = 2'b10;
  end

  // memory responder: one-cycle read latency, optional request stalls
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (have_pend) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_model.exists(pend_addr) ? mem_model[pend_addr] : 32'h0;
        have_pend     = 1'b0;
      end
      mem_req_ready = stall_en ? ~mem_req_ready : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        pend_addr = mem_req_addr;
        have_pend = 1'b1;
        if (rd_cnt < 4) rd_addr[rd_cnt] = mem_req_addr;
        rd_cnt++;
      end
    end
  end

  function automatic logic [31:0] l1a(input logic [31:0] va);
    return {TBASE, va[31:20], 2'b00};
  endfunction
  function automatic logic [31:0] d_sect(input logic [11:0] pa, input logic [1:0] ap, input logic [3:0] dm);
    return {pa, 8'h00, ap, 1'b0, dm, 3'b000, 2'b10};
  endfunction
  function automatic logic [31:0] d_coarse(input logic [21:0] b, input logic [3:0] dm);
    return {b, 1'b0, dm, 3'b000, 2'b01};
  endfunction
  function automatic logic [31:0] d_fine(input logic [19:0] b, input logic [3:0] dm);
    return {b, 3'b000, dm, 3'b000, 2'b11};
  endfunction
  function automatic logic [31:0] d_large(input logic [15:0] p, input logic [7:0] aps);
    return {p, 4'h0, aps, 2'b00, 2'b01};
  endfunction
  function automatic logic [31:0] d_small(input logic [19:0] p, input logic [7:0] aps);
    return {p, aps, 2'b00, 2'b10};
  endfunction
  function automatic logic [31:0] d_tiny(input logic [21:0] p, input logic [1:0] ap);
    return {p, 4'h0, ap, 2'b00, 2'b11};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_walk(input logic [31:0] va, input bit priv, input bit wr, input int hold);
    int n;
    rd_cnt = 0;
    @(negedge clk);
    req_va = va; req_priv = priv; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 busy after accept", {31'b0, req_ready}, 32'd0);
    n = 0;
    while (!rsp_valid && n < 200) begin @(negedge clk); n++; end
    if (!rsp_valid) chk("R11 response timeout", 32'd0, 32'd1);
    got_pa = rsp_pa; got_flt = rsp_fault;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R12 held pa", rsp_pa, got_pa);
      chk("R12 held fault", {29'b0, rsp_fault}, {29'b0, got_flt});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R11 idle after response", {31'b0, req_ready}, 32'd1);
  endtask

  task automatic expect_res(input string req, input logic [31:0] pa, input logic [2:0] f, input int reads);
    chk({req, " pa"}, got_pa, pa);
    chk({req, " fault"}, {29'b0, got_flt}, {29'b0, f});
    chk({req, " reads"}, rd_cnt, reads);
  endtask

  task automatic t_reset;
    chk("R11 reset ready", {31'b0, req_ready}, 32'd1);
    chk("R12 reset rsp_valid", {31'b0, rsp_valid}, 32'd0);
    chk("R13 reset mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
  endtask

  task automatic t_section;
    logic [31:0] va = 32'h1234_5678;
    mem_model[l1a(va)] = d_sect(12'hABC, 2'b11, 4'd0);
    do_walk(va, 1'b0, 1'b1, 0);
    expect_res("R4 section", 32'hABC4_5678, 3'd0, 1);
    chk("R1 L1 address", rd_addr[0], l1a(va));
  endtask

  task automatic t_perm;
    mem_model[l1a(32'h2000_0010)] = d_sect(12'h555, 2'b00, 4'd0);
    mem_model[l1a(32'h2010_0000)] = d_sect(12'h556, 2'b01, 4'd4);
    mem_model[l1a(32'h2020_0000)] = d_sect(12'h557, 2'b10, 4'd0);
    mem_model[l1a(32'h2030_0000)] = d_sect(12'h558, 2'b11, 4'd0);
    do_walk(32'h2000_0010, 1'b1, 1'b0, 0); expect_res("R10 ap00 priv read", 32'h5550_0010, 3'd0, 1);
    do_walk(32'h2000_0010, 1'b1, 1'b1, 0); expect_res("R10 ap00 priv write", 32'h0, 3'd4, 1);
    do_walk(32'h2000_0010, 1'b0, 1'b0, 0); expect_res("R10 ap00 user read", 32'h0, 3'd4, 1);
    do_walk(32'h2010_0000, 1'b0, 1'b0, 0); expect_res("R10 ap01 user read", 32'h0, 3'd4, 1);
    do_walk(32'h2010_0000, 1'b1, 1'b1, 0); expect_res("R10 ap01 priv write", 32'h5560_0000, 3'd0, 1);
    do_walk(32'h2020_0000, 1'b0, 1'b1, 0); expect_res("R10 ap10 user write", 32'h0, 3'd4, 1);
    do_walk(32'h2020_0000, 1'b0, 1'b0, 0); expect_res("R10 ap10 user read", 32'h5570_0000, 3'd0, 1);
    do_walk(32'h2030_0000, 1'b0, 1'b1, 0); expect_res("R10 ap11 user write", 32'h5580_0000, 3'd0, 1);
  endtask

  task automatic t_domain;
    mem_model[l1a(32'h3000_0000)] = d_sect(12'h601, 2'b00, 4'd1);
    mem_model[l1a(32'h3010_0000)] = d_coarse(22'h00_2100, 4'd2);
    mem_model[l1a(32'h3020_0000)] = d_sect(12'h603, 2'b11, 4'd3);
    do_walk(32'h3000_0044, 1'b0, 1'b1, 0); expect_res("R3 manager bypass", 32'h6010_0044, 3'd0, 1);
    do_walk(32'h3010_0000, 1'b1, 1'b0, 0); expect_res("R3 no-access domain", 32'h0, 3'd3, 1);
    do_walk(32'h3020_0000, 1'b1, 1'b0, 0); expect_res("R3 reserved domain", 32'h0, 3'd3, 1);
  endtask

  task automatic t_l1_fault;
    mem_model[l1a(32'h4000_0000)] = 32'hFFFF_FFFC;
    do_walk(32'h4000_0000, 1'b1, 1'b0, 0); expect_res("R2 L1 fault", 32'h0, 3'd1, 1);
  endtask

  task automatic t_coarse_small;
    logic [31:0] va = 32'h5012_3800;
    logic [31:0] l2 = {22'h00_2000, va[19:12], 2'b00};
    mem_model[l1a(va)] = d_coarse(22'h00_2000, 4'd0);
    mem_model[l2] = d_small(20'h77777, {2'b11, 2'b00, 2'b11, 2'b11});
    do_walk(va, 1'b0, 1'b0, 0); expect_res("R8 small subpage2 user", 32'h0, 3'd4, 2);
    chk("R5 coarse L2 address", rd_addr[1], l2);
    do_walk(va, 1'b1, 1'b0, 0); expect_res("R8 small subpage2 priv", 32'h7777_7800, 3'd0, 2);
    do_walk(32'h5012_3C00, 1'b0, 1'b1, 0); expect_res("R8 small subpage3 user", 32'h7777_7C00, 3'd0, 2);
  endtask

  task automatic t_coarse_large;
    logic [31:0] va = 32'h6045_C123;
    logic [31:0] l2 = {22'h00_2001, va[19:12], 2'b00};
    mem_model[l1a(va)] = d_coarse(22'h00_2001, 4'd0);
    mem_model[l2] = d_large(16'h9ABC, {2'b01, 2'b11, 2'b11, 2'b11});
    do_walk(va, 1'b0, 1'b0, 0); expect_res("R8 large subpage3 user", 32'h0, 3'd4, 2);
    do_walk(va, 1'b1, 1'b1, 0); expect_res("R8 large subpage3 priv", 32'h9ABC_C123, 3'd0, 2);
    chk("R5 coarse L2 address large", rd_addr[1], l2);
  endtask

  task automatic t_fine_tiny;
    logic [31:0] va = 32'h7098_7654;
    logic [31:0] l2 = {20'h00300, va[19:10], 2'b00};
    mem_model[l1a(va)] = d_fine(20'h00300, 4'd0);
    mem_model[l2] = d_tiny(22'h12_3456, 2'b10);
    do_walk(va, 1'b0, 1'b0, 0); expect_res("R9 tiny user read", {22'h12_3456, va[9:0]}, 3'd0, 2);
    chk("R6 fine L2 address", rd_addr[1], l2);
    do_walk(va, 1'b0, 1'b1, 0); expect_res("R9 tiny user write", 32'h0, 3'd4, 2);
  endtask

  task automatic t_l2_fault;
    mem_model[l1a(32'h7100_0000)] = d_fine(20'h00301, 4'd0);
    do_walk(32'h7100_0000, 1'b1, 1'b0, 0); expect_res("R7 L2 fault", 32'h0, 3'd2, 2);
  endtask

  task automatic t_backpressure;
    stall_en = 1'b1;
    do_walk(32'h1234_5678, 1'b1, 1'b0, 3); expect_res("R13 stalled section", 32'hABC4_5678, 3'd0, 1);
    do_walk(32'h5012_3C00, 1'b1, 1'b0, 2); expect_res("R13 stalled coarse", 32'h7777_7C00, 3'd0, 2);
    stall_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_section;
    t_perm;
    t_domain;
    t_l1_fault;
    t_coarse_small;
    t_coarse_large;
    t_fine_tiny;
    t_l2_fault;
    t_backpressure;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule